// File: doc/BRIEF.md
# AC-link Global Control and Reset Sequencer

This block holds the global control word of an AC-link modem controller and runs the link-side logic that this word drives. Software writes a single control register and reads back either that register or a status register. The control register can hold the link in cold reset, start a warm reset, shut the link outputs off, and enable interrupts. A warm reset drives SYNC high for a fixed number of system clocks. The request bit then stays set until the codec's bit clock is seen toggling again, and only then clears.

The codec bit clock is asynchronous. It is synchronised into the system clock and counts as running once two edges arrive with no gap longer than a timeout. A rising level on any of the three serial data inputs while the bit clock is stopped is a codec resume event. A change on any general-purpose input is also an event. Each event sets a sticky status flag, which software clears by writing 1 to it. The interrupt line is the OR of the pending flags whose enables are set. The frame-level SYNC and SDOUT from the slot framing logic pass through this block, which gates them by shut-off and cold reset.

Top module: `aclink_gctl`

## Requirements
- R1: After the synchronous reset the control register (address 0) and the status register (address 1) read 0, and `reset_n_o`, `sync_o`, `sdout_o` and `irq_o` are low.
- R2: Control bits 31:7 and status bits 31:7 and 3:1 always read 0, whatever value is written.
- R3: While control bit 3 (shut-off) is 1, `sync_o`, `sdout_o` and `reset_n_o` are low from the cycle after it is seen; when bit 3 is cleared they follow normal operation again.
- R4: An accepted warm reset drives `sync_o` high for exactly WARM_CYC consecutive cycles.
- R5: Writing 1 to control bit 2 while the bit clock is running is ignored: bit 2 reads 0 and no SYNC pulse is produced.
- R6: Once accepted, control bit 2 reads 1 and ignores writes of 0 until the bit clock is detected as running, then clears itself.
- R7: While control bit 1 (cold reset, active low) is 0, `reset_n_o` and the other link outputs are low, any warm reset in progress is abandoned, and bit-clock detection restarts.
- R8: The bit clock counts as running after its second synchronised edge, and as stopped when no edge arrives for BCLK_TMO cycles. A warm request made after the clock stops is accepted.
- R9: A rising level on `sdin[i]` while the bit clock is stopped sets status bit 4+i. The same rise while the bit clock is running sets nothing. The flag is sticky until cleared.
- R10: Any change on `gpi` sets status bit 0 regardless of control bit 0. `irq_o` reflects status bit 0 only while control bit 0 is 1.
- R11: `irq_o` is high exactly when some status bit 4+i is set together with control bit 4+i, or status bit 0 is set together with control bit 0. Writing 1 to a status bit clears it.
- R12: A pulse on `pm_rst` clears control bit 0 and leaves the other control bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pm_rst | input | 1 | Power-state return reset, clears control bit 0 |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects control, 1 selects status |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data of the selected register |
| bit_clk | input | 1 | Codec bit clock, asynchronous |
| sdin | input | 3 | Codec serial data inputs |
| gpi | input | GPI_W | General-purpose inputs, asynchronous |
| frame_sync_i | input | 1 | SYNC from the slot framing logic |
| frame_sdout_i | input | 1 | SDOUT from the slot framing logic |
| sync_o | output | 1 | Link SYNC |
| sdout_o | output | 1 | Link SDOUT |
| reset_n_o | output | 1 | Link reset, active low |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that a warm request is rejected while the bit clock runs, that an accepted warm reset stays busy until the clock is detected, that shut-off and cold reset pull the link outputs low, that status flags are sticky and that a power-state reset drops the GPI enable. Only the bench scenarios can show the full sequences: the exact SYNC pulse length, self-clearing after the bit clock restarts, detection dropping out after the timeout, and resume events being accepted or ignored depending on bit-clock activity. The bench also shows interrupt gating and write-1-to-clear across several input patterns.

// File: rtl/aclink_pkg.sv
package aclink_pkg;
  localparam int CTRL_W = 7;
  localparam int N_SDIN = 3;
  localparam int B_GIE  = 0;
  localparam int B_COLD = 1;
  localparam int B_WARM = 2;
  localparam int B_LSO  = 3;
  localparam int B_RE0  = 4;
  localparam logic [CTRL_W-1:0] CTRL_STORE_MASK = 7'h7B;
  localparam logic [CTRL_W-1:0] STAT_MASK       = 7'h71;

  typedef enum logic [1:0] {
    W_IDLE  = 2'd0,
    W_PULSE = 2'd1,
    W_WAIT  = 2'd2
  } warm_st_e;
endpackage

// File: rtl/aclink_sync.sv
module aclink_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/aclink_bclk_mon.sv
module aclink_bclk_mon #(
  parameter int TMO         = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cold_n,
  input  logic bit_clk,
  output logic running_o
);
  localparam int TW = (TMO > 1) ? $clog2(TMO) : 1;
  localparam logic [TW-1:0] TLAST = TW'(TMO - 1);

  logic          bclk_s;
  logic          bprev_q;
  logic          edge_w;
  logic [TW-1:0] tmr_q;
  logic [1:0]    ecnt_q;
  logic          running_q;

  aclink_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (bit_clk),
    .q   (bclk_s)
  );

  assign edge_w = bclk_s ^ bprev_q;

  always_ff @(posedge clk) begin
    if (rst) bprev_q <= 1'b0;
    else     bprev_q <= bclk_s;
  end

  always_ff @(posedge clk) begin
    if (rst || !cold_n) begin
      tmr_q     <= '0;
      ecnt_q    <= '0;
      running_q <= 1'b0;
    end else if (edge_w) begin
      tmr_q <= '0;
      if (ecnt_q != 2'd2) ecnt_q <= ecnt_q + 2'd1;
      if (ecnt_q != 2'd0) running_q <= 1'b1;
    end else if (tmr_q == TLAST) begin
      tmr_q     <= '0;
      ecnt_q    <= '0;
      running_q <= 1'b0;
    end else begin
      tmr_q <= tmr_q + TW'(1);
    end
  end

  assign running_o = running_q;

  // R8: detection only comes up on a synchronised edge
  p_rise_on_edge_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(running_q) |-> $past(edge_w));

  // R8: detection only drops after the full window or a cold reset
  p_hold_in_window_r8: assert property (@(posedge clk) disable iff (rst)
    (running_q && cold_n && !edge_w && tmr_q != TLAST) |=> running_q);
endmodule

// File: rtl/aclink_warm_seq.sv
module aclink_warm_seq
  import aclink_pkg::*;
#(
  parameter int WARM_CYC = 130
) (
  input  logic clk,
  input  logic rst,
  input  logic cold_n,
  input  logic req,
  input  logic bclk_run,
  output logic busy_o,
  output logic pulse_o
);
  localparam int CW = (WARM_CYC > 1) ? $clog2(WARM_CYC) : 1;
  localparam logic [CW-1:0] CLAST = CW'(WARM_CYC - 1);

  warm_st_e      state_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !cold_n) begin
      state_q <= W_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        W_IDLE: if (req) begin
          state_q <= W_PULSE;
          cnt_q   <= '0;
        end
        W_PULSE: if (cnt_q == CLAST) begin
          state_q <= W_WAIT;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
        W_WAIT: if (bclk_run) state_q <= W_IDLE;
        default: state_q <= W_IDLE;
      endcase
    end
  end

  assign busy_o  = (state_q != W_IDLE);
  assign pulse_o = (state_q == W_PULSE);

  // R6: once started, the request stays pending until the clock is detected
  p_busy_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (busy_o && cold_n && !bclk_run) |=> busy_o);

  // R7: cold reset abandons the sequence
  p_cold_abort_r7: assert property (@(posedge clk) disable iff (rst)
    !cold_n |=> !busy_o);
endmodule

// File: rtl/aclink_evt.sv
module aclink_evt
  import aclink_pkg::*;
#(
  parameter int GPI_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SDIN-1:0] sdin,
  input  logic [GPI_W-1:0]  gpi,
  input  logic              bclk_run,
  input  logic [CTRL_W-1:0] clr,
  output logic [CTRL_W-1:0] stat_o
);
  logic [N_SDIN-1:0] sdin_s, sdin_prev_q;
  logic [GPI_W-1:0]  gpi_s, gpi_prev_q;
  logic [CTRL_W-1:0] set_w;
  logic [CTRL_W-1:0] stat_q;

  aclink_sync #(.W(N_SDIN), .STAGES(SYNC_STAGES)) u_sdin_sync (
    .clk (clk), .rst (rst), .d (sdin), .q (sdin_s)
  );
  aclink_sync #(.W(GPI_W), .STAGES(SYNC_STAGES)) u_gpi_sync (
    .clk (clk), .rst (rst), .d (gpi), .q (gpi_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sdin_prev_q <= '0;
      gpi_prev_q  <= '0;
    end else begin
      sdin_prev_q <= sdin_s;
      gpi_prev_q  <= gpi_s;
    end
  end

  always_comb begin
    set_w        = '0;
    set_w[B_GIE] = |(gpi_s ^ gpi_prev_q);
    for (int i = 0; i < N_SDIN; i++)
      set_w[B_RE0+i] = sdin_s[i] & ~sdin_prev_q[i] & ~bclk_run;
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= ((stat_q & ~clr) | set_w) & STAT_MASK;
  end

  assign stat_o = stat_q;

  // R9: a resume flag stays set until software clears it
  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (stat_q[B_RE0] && !clr[B_RE0]) |=> stat_q[B_RE0]);

  // R10: a GPI flag stays set until software clears it
  p_sticky_gpi_r10: assert property (@(posedge clk) disable iff (rst)
    (stat_q[B_GIE] && !clr[B_GIE]) |=> stat_q[B_GIE]);
endmodule

// File: rtl/aclink_gctl.sv
module aclink_gctl
  import aclink_pkg::*;
#(
  parameter int GPI_W       = 4,
  parameter int WARM_CYC    = 130,
  parameter int BCLK_TMO    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pm_rst,
  input  logic             wr_en,
  input  logic             reg_addr,
  input  logic [31:0]      wr_data,
  output logic [31:0]      rd_data,
  input  logic             bit_clk,
  input  logic [2:0]       sdin,
  input  logic [GPI_W-1:0] gpi,
  input  logic             frame_sync_i,
  input  logic             frame_sdout_i,
  output logic             sync_o,
  output logic             sdout_o,
  output logic             reset_n_o,
  output logic             irq_o
);
  localparam int PAD = 32 - CTRL_W;

  logic [CTRL_W-1:0] ctrl_q;
  logic [CTRL_W-1:0] ctrl_view;
  logic [CTRL_W-1:0] stat_q;
  logic [CTRL_W-1:0] stat_clr;
  logic              ctrl_wr, stat_wr;
  logic              bclk_run, warm_busy, warm_pulse, warm_req;
  logic              link_en;
  logic              unused_wdata;

  assign unused_wdata = ^wr_data[31:CTRL_W];
  assign ctrl_wr  = wr_en && !reg_addr;
  assign stat_wr  = wr_en &&  reg_addr;
  assign warm_req = ctrl_wr && wr_data[B_WARM] && !bclk_run && !warm_busy && ctrl_q[B_COLD];
  assign stat_clr = stat_wr ? (wr_data[CTRL_W-1:0] & STAT_MASK) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= wr_data[CTRL_W-1:0] & CTRL_STORE_MASK;
      if (pm_rst)  ctrl_q[B_GIE] <= 1'b0;
    end
  end

  aclink_bclk_mon #(.TMO(BCLK_TMO), .SYNC_STAGES(SYNC_STAGES)) u_bclk (
    .clk       (clk),
    .rst       (rst),
    .cold_n    (ctrl_q[B_COLD]),
    .bit_clk   (bit_clk),
    .running_o (bclk_run)
  );

  aclink_warm_seq #(.WARM_CYC(WARM_CYC)) u_warm (
    .clk      (clk),
    .rst      (rst),
    .cold_n   (ctrl_q[B_COLD]),
    .req      (warm_req),
    .bclk_run (bclk_run),
    .busy_o   (warm_busy),
    .pulse_o  (warm_pulse)
  );

  aclink_evt #(.GPI_W(GPI_W), .SYNC_STAGES(SYNC_STAGES)) u_evt (
    .clk      (clk),
    .rst      (rst),
    .sdin     (sdin),
    .gpi      (gpi),
    .bclk_run (bclk_run),
    .clr      (stat_clr),
    .stat_o   (stat_q)
  );

  always_comb begin
    ctrl_view         = ctrl_q;
    ctrl_view[B_WARM] = warm_busy;
  end

  assign link_en = !ctrl_q[B_LSO] && ctrl_q[B_COLD];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data   <= '0;
      irq_o     <= 1'b0;
      sync_o    <= 1'b0;
      sdout_o   <= 1'b0;
      reset_n_o <= 1'b0;
    end else begin
      rd_data   <= {{PAD{1'b0}}, (reg_addr ? stat_q : ctrl_view)};
      irq_o     <= |(stat_q & ctrl_q & STAT_MASK);
      sync_o    <= link_en && (warm_pulse || frame_sync_i);
      sdout_o   <= link_en && frame_sdout_i;
      reset_n_o <= link_en;
    end
  end

  // R5: a warm request while the bit clock runs leaves the bit clear
  p_reject_r5: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && wr_data[B_WARM] && bclk_run && !warm_busy) |=> !warm_busy);

  // R7: cold reset holds the link reset low
  p_cold_low_r7: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[B_COLD] |=> (!reset_n_o && !sync_o && !sdout_o));

  // R3: shut-off pulls every link output low
  p_shutoff_r3: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[B_LSO] |=> (!sync_o && !sdout_o && !reset_n_o));

  // R4: the warm pulse reaches SYNC when the link is enabled
  p_warm_sync_r4: assert property (@(posedge clk) disable iff (rst)
    (warm_pulse && link_en) |=> sync_o);

  // R10: with all enables off, no interrupt
  p_gate_r10: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[B_GIE] && ctrl_q[6:4] == 3'b000) |=> !irq_o);

  // R12: power-state reset drops the GPI enable
  p_pm_clear_r12: assert property (@(posedge clk) disable iff (rst)
    (pm_rst && !ctrl_wr) |=> (!ctrl_q[B_GIE] && $stable(ctrl_q[6:1])));
endmodule

// File: tb/aclink_gctl_test.sv
module aclink_gctl_test;
  localparam int GPI_W = 4;
  localparam int WARM  = 10;
  localparam int TMO   = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pm_rst = 1'b0;
  logic wr_en = 1'b0;
  logic reg_addr = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic bit_clk = 1'b0;
  logic bclk_en = 1'b0;
  logic [2:0] sdin = '0;
  logic [GPI_W-1:0] gpi = '0;
  logic frame_sync_i = 1'b0;
  logic frame_sdout_i = 1'b0;
  logic sync_o, sdout_o, reset_n_o, irq_o;

  int n_tests = 0;
  int n_fail = 0;
  bit started = 0;
  bit done = 0;

  aclink_gctl #(.GPI_W(GPI_W), .WARM_CYC(WARM), .BCLK_TMO(TMO), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .pm_rst(pm_rst), .wr_en(wr_en), .reg_addr(reg_addr),
    .wr_data(wr_data), .rd_data(rd_data), .bit_clk(bit_clk), .sdin(sdin), .gpi(gpi),
    .frame_sync_i(frame_sync_i), .frame_sdout_i(frame_sdout_i), .sync_o(sync_o),
    .sdout_o(sdout_o), .reset_n_o(reset_n_o), .irq_o(irq_o)
  );

  always #2 clk = ~clk;
  always begin
    #21;
    if (bclk_en) bit_clk = ~bit_clk;
  end

  // behavioural reference model
  logic [6:0] m_ctrl, m_stat;
  logic [31:0] m_rd;
  logic m_irq, m_sync, m_sdout, m_rstn, m_run;
  logic m_bq1, m_bq2, m_bprev;
  logic [2:0] m_sq1, m_sq2, m_sprev;
  logic [GPI_W-1:0] m_gq1, m_gq2, m_gprev;
  int m_tmr, m_ecnt, m_wst, m_wcnt;

  task automatic model_step();
    logic edg, run_o, cold, en, req, gchg;
    logic [6:0] ctrl_o, stat_o, setv, clrv;
    logic [2:0] rise;
    int wst_o;
    if (rst) begin
      m_ctrl = 0; m_stat = 0; m_rd = 0; m_irq = 0; m_sync = 0; m_sdout = 0; m_rstn = 0;
      m_run = 0; m_bq1 = 0; m_bq2 = 0; m_bprev = 0; m_sq1 = 0; m_sq2 = 0; m_sprev = 0;
      m_gq1 = 0; m_gq2 = 0; m_gprev = 0; m_tmr = 0; m_ecnt = 0; m_wst = 0; m_wcnt = 0;
      return;
    end
    edg = m_bq2 ^ m_bprev; run_o = m_run; ctrl_o = m_ctrl; stat_o = m_stat;
    wst_o = m_wst; cold = ctrl_o[1];
    m_rd = reg_addr ? {25'b0, stat_o} : {25'b0, ctrl_o | ((wst_o != 0) ? 7'h04 : 7'h00)};
    m_irq = (stat_o & ctrl_o & 7'h71) != 0;
    en = !ctrl_o[3] && cold;
    m_sync = en && (wst_o == 1 || frame_sync_i);
    m_sdout = en && frame_sdout_i;
    m_rstn = en;
    if (!cold) begin m_tmr = 0; m_ecnt = 0; m_run = 0; end
    else if (edg) begin
      m_tmr = 0;
      if (m_ecnt >= 1) m_run = 1;
      if (m_ecnt < 2) m_ecnt++;
    end else if (m_tmr == TMO - 1) begin m_tmr = 0; m_ecnt = 0; m_run = 0; end
    else m_tmr++;
    req = wr_en && !reg_addr && wr_data[2] && !run_o && wst_o == 0 && cold;
    if (!cold) begin m_wst = 0; m_wcnt = 0; end
    else if (wst_o == 0) begin if (req) begin m_wst = 1; m_wcnt = 0; end end
    else if (wst_o == 1) begin
      if (m_wcnt == WARM - 1) begin m_wst = 2; m_wcnt = 0; end else m_wcnt++;
    end else if (run_o) m_wst = 0;
    if (wr_en && !reg_addr) m_ctrl = wr_data[6:0] & 7'h7B;
    if (pm_rst) m_ctrl[0] = 1'b0;
    rise = m_sq2 & ~m_sprev & {3{!run_o}};
    gchg = (m_gq2 != m_gprev);
    setv = {rise, 3'b000, gchg};
    clrv = (wr_en && reg_addr) ? (wr_data[6:0] & 7'h71) : 7'h00;
    m_stat = ((m_stat & ~clrv) | setv) & 7'h71;
    m_bprev = m_bq2; m_bq2 = m_bq1; m_bq1 = bit_clk;
    m_sprev = m_sq2; m_sq2 = m_sq1; m_sq1 = sdin;
    m_gprev = m_gq2; m_gq2 = m_gq1; m_gq1 = gpi;
  endtask

  always @(posedge clk) begin
    model_step();
    started <= 1'b1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      if (n_fail <= 30) $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      check("R1 rd_data vs model", rd_data, m_rd);
      check("R11 irq_o vs model", {31'b0, irq_o}, {31'b0, m_irq});
      check("R4 sync_o vs model", {31'b0, sync_o}, {31'b0, m_sync});
      check("R3 sdout_o vs model", {31'b0, sdout_o}, {31'b0, m_sdout});
      check("R7 reset_n_o vs model", {31'b0, reset_n_o}, {31'b0, m_rstn});
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; reg_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0; wr_data = 0;
  endtask

  task automatic rd(input logic a, output logic [31:0] v);
    @(negedge clk); reg_addr = a;
    @(negedge clk); @(negedge clk); v = rd_data;
  endtask

  initial begin
    #100000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int cnt;
    cyc(5); rst = 0; cyc(1);
    rd(0, v); check("R1 control after reset", v, 0);
    rd(1, v); check("R1 status after reset", v, 0);
    check("R1 reset_n_o low", {31'b0, reset_n_o}, 0);
    // R2: reserved bits
    wr(0, 32'hFFFF_FF82); rd(0, v); check("R2 reserved control bits", v, 32'h2);
    cyc(2); check("R7 reset_n_o released", {31'b0, reset_n_o}, 1);
    // R4/R6: warm reset with clock stopped
    wr(0, 32'h6); cnt = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (sync_o) cnt++; end
    check("R4 sync pulse length", cnt, WARM);
    rd(0, v); check("R6 warm bit held", v, 32'h6);
    wr(0, 32'h2); rd(0, v); check("R6 write 0 ignored while pending", v, 32'h6);
    bclk_en = 1; cyc(40);
    rd(0, v); check("R6 self clear after bit_clk", v, 32'h2);
    // R5: rejected while running
    wr(0, 32'h6); cnt = 0;
    for (int i = 0; i < 15; i++) begin @(negedge clk); if (sync_o) cnt++; end
    check("R5 no sync when rejected", cnt, 0);
    rd(0, v); check("R5 warm bit stays 0", v, 32'h2);
    // R9: resume ignored while running
    sdin = 3'b010; cyc(10); rd(1, v); check("R9 resume ignored while running", v, 0);
    sdin = 3'b000; cyc(5);
    // R8: stopped after timeout, request accepted
    bclk_en = 0; cyc(40);
    wr(0, 32'h6); rd(0, v); check("R8 warm accepted after stop", v, 32'h6);
    // R7: cold reset abandons warm
    wr(0, 32'h0); rd(0, v); check("R7 cold abort", v, 32'h0);
    check("R7 reset_n_o low", {31'b0, reset_n_o}, 0);
    wr(0, 32'h2); cyc(40);
    // R9/R11: resume event and gating
    sdin = 3'b010; cyc(10); rd(1, v); check("R9 resume sdin1", v, 32'h20);
    check("R11 irq gated off", {31'b0, irq_o}, 0);
    wr(0, 32'h22); cyc(3); check("R11 irq enabled", {31'b0, irq_o}, 1);
    wr(1, 32'h20); cyc(3); check("R11 irq after clear", {31'b0, irq_o}, 0);
    rd(1, v); check("R11 status cleared", v, 0);
    sdin = 3'b000; cyc(5);
    sdin = 3'b101; cyc(10); rd(1, v); check("R9 resume sdin0 and sdin2", v, 32'h50);
    check("R11 irq only enabled input", {31'b0, irq_o}, 0);
    wr(1, 32'h7F); sdin = 3'b000; cyc(5); rd(1, v); check("R2 status reserved", v, 0);
    // R10: GPI
    gpi = 4'h3; cyc(6); rd(1, v); check("R10 gpi status set", v, 32'h01);
    check("R10 irq gated", {31'b0, irq_o}, 0);
    wr(0, 32'h23); cyc(3); check("R10 irq with enable", {31'b0, irq_o}, 1);
    // R12
    @(negedge clk); pm_rst = 1; @(negedge clk); pm_rst = 0; cyc(2);
    rd(0, v); check("R12 pm reset clears bit0 only", v, 32'h22);
    check("R10 irq after enable drop", {31'b0, irq_o}, 0);
    wr(1, 32'h01); cyc(3);
    // R3: shut-off
    frame_sync_i = 1; frame_sdout_i = 1; cyc(3);
    check("R3 sdout passes", {31'b0, sdout_o}, 1);
    wr(0, 32'hA); cyc(2);
    check("R3 sdout low", {31'b0, sdout_o}, 0);
    check("R3 sync low", {31'b0, sync_o}, 0);
    check("R3 reset_n low", {31'b0, reset_n_o}, 0);
    wr(0, 32'h2); cyc(2); check("R3 restored", {31'b0, sdout_o}, 1);
    // R7: cold gates framing outputs
    wr(0, 32'h0); cyc(2);
    check("R7 sdout low in cold", {31'b0, sdout_o}, 0);
    check("R7 sync low in cold", {31'b0, sync_o}, 0);
    cyc(3);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule